// File: doc/BRIEF.md
# Flash Status Polling Engine

This engine waits on an external serial memory by reading its status over and over until a chosen condition shows up. Each read is issued as a one-cycle request to a command sequencer. The sequencer performs the serial transfer, then returns the status bytes, packed into one 32-bit word, together with a done strobe. The engine tests that word against a mask and a compare value, and raises a sticky match flag when the test passes. Between reads it waits a programmable number of clock cycles.

The test has two forms. In all-bits form, every selected bit must equal the compare value. In any-bit form, one selected bit equal to the compare value is enough. Bits above the configured status length never take part in the test. With self-stop on, the engine goes idle at the first match. With self-stop off, it keeps polling until it is aborted or disabled.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, busy, rd_req and match_flag are low. A start pulse while idle and enabled raises busy at the next edge, and rd_req is high for exactly that one cycle. A start while busy has no effect.
- R2: `cfg_nbytes` encodes the status length as 0..3 for 1..4 bytes, with byte 0 in bits 7:0. Bits at and above bit 8*(cfg_nbytes+1) are always treated as masked out.
- R3: With `cfg_or_mode`=0, a read matches when every selected bit (mask bit 1, inside the length) of rd_data equals the same bit of cfg_match. An empty selection always matches.
- R4: With `cfg_or_mode`=1, a read matches when at least one selected bit equals cfg_match. An empty selection never matches.
- R5: Take a done strobe at cycle t that does not end polling. The next rd_req is high in cycle t+cfg_interval+1, so an interval of 0 issues the next request in the very next cycle.
- R6: With `cfg_auto_stop`=1, a matching read makes busy low at the next edge and no further request follows. With it 0, polling goes on after a match.
- R7: match_flag rises on the edge that takes a matching done strobe, and stays high until a match_clr pulse. When a match and match_clr fall in the same cycle, the flag stays set.
- R8: abort, or enable held low, makes busy low at the next edge. A start while enable is low is ignored.
- R9: A done strobe while no read is pending has no effect on match_flag or on the request timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low forces idle |
| start | input | 1 | Begin polling (pulse) |
| abort | input | 1 | Stop polling (pulse) |
| cfg_mask | input | 32 | Bit select for the test |
| cfg_match | input | 32 | Compare value |
| cfg_nbytes | input | 2 | Status length minus one, in bytes |
| cfg_or_mode | input | 1 | 0 all-bits test, 1 any-bit test |
| cfg_auto_stop | input | 1 | Stop on first match |
| cfg_interval | input | 16 | Idle cycles between reads |
| rd_done | input | 1 | Status read finished strobe |
| rd_data | input | 32 | Returned status word |
| match_clr | input | 1 | Clear strobe for match_flag |
| rd_req | output | 1 | Status read request (one-cycle pulse) |
| match_flag | output | 1 | Sticky match indication |
| busy | output | 1 | Polling in progress |

## Verification
The assertions take the configuration to be steady while busy. The interval check measures the wait against the live cfg_interval, so a change mid-poll would break it. The stimulus therefore changes configuration only while the engine is idle, and waits a few cycles after each abort before it reconfigures. The sequencer model in the bench answers each request after a fixed latency. It sends its stray done strobes only when no read is pending, so no stray strobe can land on a real one.

// File: rtl/flash_status_poller.sv
module flash_status_poller #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        start,
  input  logic                        abort,
  input  logic [DW-1:0]               cfg_mask,
  input  logic [DW-1:0]               cfg_match,
  input  logic [$clog2(DW/8)-1:0]     cfg_nbytes,
  input  logic                        cfg_or_mode,
  input  logic                        cfg_auto_stop,
  input  logic [IW-1:0]               cfg_interval,
  input  logic                        rd_done,
  input  logic [DW-1:0]               rd_data,
  input  logic                        match_clr,
  output logic                        rd_req,
  output logic                        match_flag,
  output logic                        busy
);
  localparam int NB = DW / 8;
  localparam int BW = $clog2(NB);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_GAP} st_t;
  st_t           state;
  logic [IW-1:0] gap_cnt;
  logic [DW-1:0] len_mask;

  for (genvar b = 0; b < NB; b++) begin : g_len
    assign len_mask[b*8 +: 8] = (cfg_nbytes >= BW'(b)) ? 8'hFF : 8'h00;
  end

  logic [DW-1:0] sel, eq_bits;
  logic          hit, halt, take;

  assign sel     = cfg_mask & len_mask;
  assign eq_bits = ~(rd_data ^ cfg_match);
  assign hit     = cfg_or_mode ? |(eq_bits & sel) : &(eq_bits | ~sel);
  assign halt    = abort | ~enable;
  assign take    = (state == S_WAIT) & rd_done & ~halt;

  assign rd_req = (state == S_REQ);
  assign busy   = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      gap_cnt <= '0;
    end else if (halt) begin
      state   <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (start) state <= S_REQ;
        S_REQ:  state <= S_WAIT;
        S_WAIT: if (rd_done) begin
          if (hit && cfg_auto_stop)  state <= S_IDLE;
          else if (cfg_interval == '0) state <= S_REQ;
          else begin
            state   <= S_GAP;
            gap_cnt <= cfg_interval;
          end
        end
        S_GAP: begin
          gap_cnt <= gap_cnt - 1'b1;
          if (gap_cnt == IW'(1)) state <= S_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             match_flag <= 1'b0;
    else if (take && hit)   match_flag <= 1'b1;
    else if (match_clr)     match_flag <= 1'b0;
  end

  logic [IW:0] since_done;
  logic        after_done;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_done <= '0;
      after_done <= 1'b0;
    end else if (take) begin
      since_done <= '0;
      after_done <= 1'b1;
    end else begin
      if (since_done != '1) since_done <= since_done + 1'b1;
      if (state == S_IDLE) after_done <= 1'b0;
    end
  end

  a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);
  a_r5_interval: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && after_done) |-> since_done == {1'b0, cfg_interval});
  a_r6_self_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit && cfg_auto_stop) |=> !busy);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !match_clr) |=> match_flag);
  a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(rd_done));
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (abort || !enable) |=> !busy);
  a_r9_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && state != S_WAIT && !match_clr) |=> $stable(match_flag));
endmodule

// File: tb/flash_status_poller_tb.sv
module flash_status_poller_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b1, start = 1'b0, abort = 1'b0;
  logic [31:0] cfg_mask = '0, cfg_match = '0;
  logic [1:0]  cfg_nbytes = '0;
  logic cfg_or_mode = 1'b0, cfg_auto_stop = 1'b1;
  logic [15:0] cfg_interval = '0;
  logic rd_done = 1'b0, match_clr = 1'b0;
  logic [31:0] rd_data = '0;
  logic rd_req, match_flag, busy;

  always #2 clk = ~clk;

  flash_status_poller u_dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  string cur = "R1";
  logic [31:0] seq [4];
  int nread = 0, pend = 0, lat = 2, last_done = -1, gap_meas = -1;
  bit clr_req = 0, clr_with_done = 0, stray_go = 0;
  logic [31:0] stray_data = '0;

  int m_ph = 0, m_left = 0;
  bit m_flag = 0;

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  function automatic bit ref_hit(input logic [31:0] d);
    int eq = 0, ne = 0;
    for (int i = 0; i < 8 * (cfg_nbytes + 1); i++)
      if (cfg_mask[i]) begin
        if (d[i] == cfg_match[i]) eq++; else ne++;
      end
    return cfg_or_mode ? (eq > 0) : (ne == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_flag = 0;
    end else begin
      bit tk, h;
      tk = (m_ph == 2) && rd_done && enable && !abort;
      h  = ref_hit(rd_data);
      if (tk && h) m_flag = 1; else if (match_clr) m_flag = 0;
      if (abort || !enable) m_ph = 0;
      else if (m_ph == 0) begin if (start) m_ph = 1; end
      else if (m_ph == 1) m_ph = 2;
      else if (m_ph == 2) begin
        if (tk) begin
          if (h && cfg_auto_stop) m_ph = 0;
          else if (cfg_interval == 0) m_ph = 1;
          else begin m_ph = 3; m_left = cfg_interval; end
        end
      end else begin
        m_left--;
        if (m_left == 0) m_ph = 1;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    cyc++;
    if (rst_n) begin
      chk({cur, " rd_req"}, rd_req, m_ph == 1);
      chk({cur, " busy"}, busy, m_ph != 0);
      chk({cur, " match_flag"}, match_flag, m_flag);
    end
    rd_done = 0;
    match_clr = clr_req;
    clr_req = 0;
    if (stray_go) begin
      rd_done = 1; rd_data = stray_data; stray_go = 0;
    end else if (pend == 1) begin
      rd_done = 1;
      rd_data = seq[nread > 3 ? 3 : nread];
      nread++;
      last_done = cyc;
      if (clr_with_done) match_clr = 1;
    end
    if (pend > 0) pend--;
    if (rd_req) begin
      if (last_done >= 0) gap_meas = cyc - last_done;
      pend = lat;
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic go(input logic [31:0] s0, s1, s2, s3);
    seq[0] = s0; seq[1] = s1; seq[2] = s2; seq[3] = s3;
    nread = 0; last_done = -1; gap_meas = -1;
    tick(1); start = 1; tick(1); start = 0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && busy; i++) tick(1);
  endtask

  task automatic stop_all;
    abort = 1; tick(1); abort = 0;
    chk("R8 abort idle", busy, 0);
    tick(6);
  endtask

  task automatic clear_flag;
    clr_req = 1; tick(3);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    cur = "R1";
    chk("R1 reset busy", busy, 0);
    chk("R1 reset req", rd_req, 0);
    chk("R1 reset flag", match_flag, 0);

    cur = "R5";
    cfg_mask = 32'h1; cfg_match = 32'h0; cfg_nbytes = 0; cfg_interval = 3;
    cfg_or_mode = 0; cfg_auto_stop = 1;
    go(32'h1, 32'h1, 32'h0, 32'h0);
    tick(1); start = 1; tick(1); start = 0;
    wait_idle(200);
    chk("R6 reads until match", nread, 3);
    chk("R5 done-to-request gap", gap_meas, 4);
    chk("R7 flag after match", match_flag, 1);
    tick(4);
    chk("R6 no request after stop", nread, 3);
    clear_flag;
    chk("R7 flag cleared", match_flag, 0);

    cur = "R2";
    cfg_mask = 32'hFFFF_FFFF; cfg_match = 32'hA5; cfg_interval = 0;
    go(32'h1234_56A5, 32'h1234_56A5, 32'h1234_56A5, 32'h1234_56A5);
    wait_idle(100);
    chk("R2 upper bytes ignored", match_flag, 1);
    chk("R2 one read", nread, 1);
    clear_flag;
    cfg_nbytes = 1; cfg_interval = 2;
    go(32'h0000_A5A5, 32'h0000_A5A5, 32'h0000_A5A5, 32'h0000_A5A5);
    tick(40);
    chk("R2 byte1 counted", match_flag, 0);
    chk("R2 still polling", busy, 1);
    stop_all;

    cur = "R4";
    cfg_nbytes = 0; cfg_or_mode = 1; cfg_mask = 32'h0F; cfg_match = 32'h05; cfg_interval = 1;
    go(32'h0A, 32'h0A, 32'h0B, 32'h0B);
    wait_idle(100);
    chk("R4 any-bit match on third read", nread, 3);
    chk("R4 flag", match_flag, 1);
    clear_flag;
    cfg_mask = 32'h0;
    go(32'h05, 32'h05, 32'h05, 32'h05);
    tick(30);
    chk("R4 empty selection never matches", match_flag, 0);
    stop_all;

    cur = "R3";
    cfg_or_mode = 0; cfg_mask = 32'h0; cfg_match = 32'h0; cfg_interval = 0;
    go(32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0);
    wait_idle(100);
    chk("R3 empty selection matches", match_flag, 1);
    chk("R3 single read", nread, 1);
    clear_flag;
    cfg_mask = 32'hF0; cfg_match = 32'h50;
    go(32'h5F, 32'h5F, 32'h5F, 32'h5F);
    wait_idle(100);
    chk("R3 unselected bits differ", match_flag, 1);
    clear_flag;

    cur = "R6";
    cfg_auto_stop = 0; cfg_mask = 32'hFF; cfg_match = 32'h3C; cfg_interval = 2;
    clr_with_done = 1;
    go(32'h3C, 32'h3C, 32'h3C, 32'h3C);
    tick(12);
    start = 1; tick(1); start = 0;
    tick(28);
    chk("R6 keeps polling", busy, 1);
    chk("R6 several reads", nread > 3, 1);
    chk("R7 set wins over clear", match_flag, 1);
    clr_with_done = 0;
    stop_all;
    clear_flag;

    cur = "R8";
    cfg_auto_stop = 1;
    go(32'h0, 32'h0, 32'h0, 32'h0);
    tick(10);
    enable = 0; tick(1);
    chk("R8 disable idles", busy, 0);
    start = 1; tick(1); start = 0; tick(1);
    chk("R8 start ignored when disabled", busy, 0);
    enable = 1; tick(6);

    cur = "R9";
    cfg_mask = 32'h0;
    stray_data = 32'h0; stray_go = 1; tick(3);
    chk("R9 stray done when idle", match_flag, 0);
    cfg_mask = 32'hFF; cfg_match = 32'h3C; cfg_interval = 20;
    go(32'h0, 32'h0, 32'h0, 32'h0);
    tick(8);
    stray_data = 32'h3C; stray_go = 1; tick(3);
    chk("R9 stray done in gap", match_flag, 0);
    tick(20);
    chk("R9 gap timing kept", gap_meas, 21);
    stop_all;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule